// File: doc/BRIEF.md
# Quadrature Position Counter

This block tracks the position of a rotary or linear encoder. Two phase inputs, A and B, are shifted a quarter cycle apart. The block decodes the transitions between them into up or down steps on a 32-bit position count. A run-time field picks the resolution:
- one count per full input cycle (X1),
- two counts per cycle, on both edges of A (X2),
- four counts per cycle, on every edge of A and B (X4).

A third input carries the encoder's index mark. When index loading is enabled, its rising edge reloads the count from the load-value port.

The A, B and index inputs each pass through a two-flop synchroniser. An optional debounce filter follows, which accepts a new level only after it has held for a fixed number of clocks. Software can write a starting value and sees the live count at all times. A compare constant is also provided. When the count is updated to a value equal to that constant, and the interrupt is enabled, a pending flag is set. The flag stays set until software pulses the clear input.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the count is 0 and the interrupt flag is 0.
- R2: With resolution field 2'b00 (X1), a forward cycle of {A,B} (00,10,11,01,00) adds 1 and a reverse cycle (00,01,11,10,00) subtracts 1. Only edges of A seen while B is low count.
- R3: With resolution field 2'b01 (X2), every edge of A counts, so a forward cycle adds 2 and a reverse cycle subtracts 2.
- R4: With resolution field 2'b10 or 2'b11 (X4), every edge of A or B counts, so a forward cycle adds 4 and a reverse cycle subtracts 4.
- R5: A transition in which A and B change in the same filtered sample leaves the count unchanged.
- R6: The mode field ctrlMode[2:0] enables counting and index loading only when it holds 3'b001. Any other value freezes the count against phase and index activity.
- R7: A one-cycle pulse on loadStrobe sets the count to loadValue at the next clock edge. This has priority over index loads and steps.
- R8: With indexEn high and the mode set to 3'b001, a rising edge of the filtered index input copies loadValue into the count. With indexEn low, index edges have no effect.
- R9: When the count is updated to a value equal to constA while irqEn is high, irqPending is set. It stays set through later counts until irqClear is pulsed. An update to constA while irqEn is low does not set it.
- R10: With debounceEn high, a new input level must persist for 4 synchronised clocks (DEB_CYCLES) before it is accepted, so a 3-clock glitch is ignored. With debounceEn low, a change is counted within 5 clocks.
- R11: The count wraps modulo 2^32, so a down step from 0 gives 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| phaseA | input | 1 | Encoder phase A (asynchronous) |
| phaseB | input | 1 | Encoder phase B (asynchronous) |
| phaseIdx | input | 1 | Encoder index mark (asynchronous) |
| ctrlMode | input | 3 | Counter mode; 3'b001 selects quadrature counting |
| ctrlRes | input | 2 | Resolution: 00 X1, 01 X2, 10/11 X4 |
| debounceEn | input | 1 | Enable input debounce filter |
| indexEn | input | 1 | Enable index-driven load |
| loadStrobe | input | 1 | Load count from loadValue |
| loadValue | input | 32 | Load value for software and index loads |
| constA | input | 32 | Compare constant |
| irqEn | input | 1 | Enable setting of the interrupt flag |
| irqClear | input | 1 | Clear the pending interrupt flag |
| count | output | 32 | Current position count |
| irqPending | output | 1 | Pending compare-match interrupt |

## Verification
The main sweep runs each of the four resolution codes in both directions, with the debounce filter both off and on, over three full phase cycles. Each run starts from a loaded base, so a per-cycle step of 1, 2 or 4 tells the decoders apart and the sign tells the direction. Separate patterns cover the following:
- simultaneous A/B changes, which must be rejected;
- a 3-clock glitch against a held change, which separates the debounced path from the raw one;
- a reverse step from zero, which exposes wrap handling;
- index pulses with index loading enabled and disabled, and under a non-quadrature mode.

The compare flag is driven through reaching the constant, counting past it, clearing it, and matching with the enable low.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam logic [2:0] MODE_QUAD = 3'b001;
  localparam logic [1:0] RES_X1    = 2'b00;
  localparam logic [1:0] RES_X2    = 2'b01;

  typedef struct packed {
    logic stepEn;
    logic stepUp;
    logic idxLoad;
  } qpcStrobe_t;
endpackage

// File: rtl/qpc_filter.sv
module qpc_filter #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  input  logic debounceEn,
  output logic dout
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      holdCnt <= '0;
      dout    <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], din};
      if (!debounceEn) begin
        dout    <= syncQ[1];
        holdCnt <= '0;
      end else if (syncQ[1] == dout) begin
        holdCnt <= '0;
      end else if (holdCnt == CW'(DEB_CYCLES - 1)) begin
        dout    <= syncQ[1];
        holdCnt <= '0;
      end else begin
        holdCnt <= holdCnt + CW'(1);
      end
    end
  end

  // R10
  stable_when_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (debounceEn && syncQ[1] == dout) |=> (dout == $past(dout)));
endmodule

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
#(
  parameter int DEB_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseA,
  input  logic       phaseB,
  input  logic       phaseIdx,
  input  logic       debounceEn,
  input  logic [2:0] ctrlMode,
  input  logic [1:0] ctrlRes,
  input  logic       indexEn,
  output qpcStrobe_t strb
);
  localparam int NIN = 3;

  logic [NIN-1:0] rawIn;
  logic [NIN-1:0] fIn;
  logic [NIN-1:0] prevIn;
  logic aChg, bChg, quadOn, phaseXor;

  assign rawIn = {phaseIdx, phaseB, phaseA};

  for (genvar i = 0; i < NIN; i++) begin : g_filt
    qpc_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
      .clk        (clk),
      .rstN       (rstN),
      .din        (rawIn[i]),
      .debounceEn (debounceEn),
      .dout       (fIn[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= fIn;
  end

  assign aChg     = fIn[0] ^ prevIn[0];
  assign bChg     = fIn[1] ^ prevIn[1];
  assign phaseXor = fIn[0] ^ fIn[1];
  assign quadOn   = (ctrlMode == MODE_QUAD);

  always_comb begin
    strb = '0;
    case (ctrlRes)
      RES_X1: begin
        strb.stepEn = aChg && !bChg && !fIn[1];
        strb.stepUp = fIn[0];
      end
      RES_X2: begin
        strb.stepEn = aChg && !bChg;
        strb.stepUp = phaseXor;
      end
      default: begin
        strb.stepEn = aChg ^ bChg;
        strb.stepUp = aChg ? phaseXor : ~phaseXor;
      end
    endcase
    strb.stepEn  = strb.stepEn && quadOn;
    strb.idxLoad = quadOn && indexEn && fIn[2] && !prevIn[2];
  end

  // R5
  no_double_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aChg && bChg) |-> !strb.stepEn);

  // R6
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlMode != MODE_QUAD) |-> (!strb.stepEn && !strb.idxLoad));
endmodule

// File: rtl/qpc_dp.sv
module qpc_dp
  import qpc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  qpcStrobe_t       strb,
  input  logic             loadStrobe,
  input  logic [CNT_W-1:0] loadValue,
  input  logic [CNT_W-1:0] constA,
  input  logic             irqEn,
  input  logic             irqClear,
  output logic [CNT_W-1:0] count,
  output logic             irqPending
);
  logic [CNT_W-1:0] nextCount;
  logic             upd;
  logic             setEvt;

  always_comb begin
    upd       = 1'b1;
    nextCount = count;
    if (loadStrobe || strb.idxLoad) nextCount = loadValue;
    else if (strb.stepEn)           nextCount = strb.stepUp ? count + CNT_W'(1) : count - CNT_W'(1);
    else                            upd = 1'b0;
  end

  assign setEvt = upd && irqEn && (nextCount == constA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count      <= '0;
      irqPending <= 1'b0;
    end else begin
      count      <= nextCount;
      irqPending <= setEvt | (irqPending & ~irqClear);
    end
  end

  // R7
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> (count == $past(loadValue)));

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepEn && !loadStrobe && !strb.idxLoad) |=>
      ((count == $past(count) + CNT_W'(1)) || (count == $past(count) - CNT_W'(1))));

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending) |-> $past(irqEn));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !irqClear) |=> irqPending);
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int DEB_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic             phaseIdx,
  input  logic [2:0]       ctrlMode,
  input  logic [1:0]       ctrlRes,
  input  logic             debounceEn,
  input  logic             indexEn,
  input  logic             loadStrobe,
  input  logic [CNT_W-1:0] loadValue,
  input  logic [CNT_W-1:0] constA,
  input  logic             irqEn,
  input  logic             irqClear,
  output logic [CNT_W-1:0] count,
  output logic             irqPending
);
  qpcStrobe_t strb;

  qpc_ctrl #(.DEB_CYCLES(DEB_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .phaseA     (phaseA),
    .phaseB     (phaseB),
    .phaseIdx   (phaseIdx),
    .debounceEn (debounceEn),
    .ctrlMode   (ctrlMode),
    .ctrlRes    (ctrlRes),
    .indexEn    (indexEn),
    .strb       (strb)
  );

  qpc_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .loadStrobe (loadStrobe),
    .loadValue  (loadValue),
    .constA     (constA),
    .irqEn      (irqEn),
    .irqClear   (irqClear),
    .count      (count),
    .irqPending (irqPending)
  );
endmodule

// File: tb/tb_quad_pos_counter.sv
`timescale 1ns/1ps
module tb_quad_pos_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phaseA = 1'b0, phaseB = 1'b0, phaseIdx = 1'b0;
  logic [2:0]  ctrlMode = 3'b001;
  logic [1:0]  ctrlRes = 2'b00;
  logic        debounceEn = 1'b0, indexEn = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [31:0] loadValue = '0, constA = 32'hFFFF_0000;
  logic        irqEn = 1'b0, irqClear = 1'b0;
  logic [31:0] count;
  logic        irqPending;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  quad_pos_counter dut (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB), .phaseIdx(phaseIdx),
    .ctrlMode(ctrlMode), .ctrlRes(ctrlRes), .debounceEn(debounceEn), .indexEn(indexEn),
    .loadStrobe(loadStrobe), .loadValue(loadValue), .constA(constA), .irqEn(irqEn),
    .irqClear(irqClear), .count(count), .irqPending(irqPending)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setAB(input logic a, input logic b);
    @(negedge clk);
    phaseA = a;
    phaseB = b;
    repeat (12) @(negedge clk);
  endtask

  task automatic fwdCycle();
    setAB(1, 0); setAB(1, 1); setAB(0, 1); setAB(0, 0);
  endtask

  task automatic revCycle();
    setAB(0, 1); setAB(1, 1); setAB(1, 0); setAB(0, 0);
  endtask

  task automatic loadCount(input logic [31:0] v);
    @(negedge clk);
    loadValue  = v;
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  task automatic pulseIdx();
    @(negedge clk);
    phaseIdx = 1'b1;
    repeat (12) @(negedge clk);
    phaseIdx = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(count == 32'd0, "R1 count", count, 32'd0);
    check(irqPending == 1'b0, "R1 irq", {31'd0, irqPending}, 32'd0);

    // R7 software load
    loadCount(32'hDEAD_BEEF);
    check(count == 32'hDEAD_BEEF, "R7 load", count, 32'hDEAD_BEEF);

    // R2 R3 R4 R10: sweep resolution x direction x debounce
    for (int deb = 0; deb < 2; deb++) begin
      for (int res = 0; res < 4; res++) begin
        for (int dirn = 0; dirn < 2; dirn++) begin
          int k;
          debounceEn = deb[0];
          ctrlRes    = res[1:0];
          k = (res == 0) ? 1 : (res == 1) ? 2 : 4;
          loadCount(32'd100);
          for (int c = 1; c <= 3; c++) begin
            logic [31:0] exp;
            if (dirn == 0) begin
              fwdCycle();
              exp = 32'd100 + 32'(k * c);
            end else begin
              revCycle();
              exp = 32'd100 - 32'(k * c);
            end
            if (res == 0)      check(count == exp, "R2 X1 sweep", count, exp);
            else if (res == 1) check(count == exp, "R3 X2 sweep", count, exp);
            else               check(count == exp, "R4 X4 sweep", count, exp);
          end
        end
      end
    end

    // R11 wrap below zero
    debounceEn = 1'b0;
    ctrlRes = 2'b00;
    loadCount(32'd0);
    revCycle();
    check(count == 32'hFFFF_FFFF, "R11 wrap", count, 32'hFFFF_FFFF);

    // R5 simultaneous change ignored (X4)
    ctrlRes = 2'b10;
    loadCount(32'd50);
    setAB(1, 1);
    check(count == 32'd50, "R5 double rise", count, 32'd50);
    setAB(0, 0);
    check(count == 32'd50, "R5 double fall", count, 32'd50);

    // R10 raw path reacts within 5 clocks
    base = count;
    @(negedge clk);
    phaseA = 1'b1;
    repeat (5) @(negedge clk);
    check(count == base + 32'd1, "R10 no-debounce latency", count, base + 32'd1);
    setAB(0, 0);

    // R10 3-clock glitch filtered out
    debounceEn = 1'b1;
    base = count;
    @(negedge clk);
    phaseA = 1'b1;
    repeat (3) @(negedge clk);
    phaseA = 1'b0;
    begin
      bit steady = 1'b1;
      logic [31:0] seen = count;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (count != base) begin
          steady = 1'b0;
          seen = count;
        end
      end
      check(steady, "R10 glitch ignored", seen, base);
    end
    debounceEn = 1'b0;

    // R8 index load
    ctrlRes = 2'b10;
    indexEn = 1'b1;
    loadValue = 32'h1234_5678;
    pulseIdx();
    check(count == 32'h1234_5678, "R8 index load", count, 32'h1234_5678);
    indexEn = 1'b0;
    loadValue = 32'h0000_ABCD;
    pulseIdx();
    check(count == 32'h1234_5678, "R8 index disabled", count, 32'h1234_5678);

    // R6 non-quadrature mode freezes count
    ctrlMode = 3'b100;
    indexEn = 1'b1;
    fwdCycle();
    check(count == 32'h1234_5678, "R6 mode phase", count, 32'h1234_5678);
    pulseIdx();
    check(count == 32'h1234_5678, "R6 mode index", count, 32'h1234_5678);
    ctrlMode = 3'b001;
    indexEn = 1'b0;

    // R9 compare interrupt
    ctrlRes = 2'b00;
    constA = 32'd5;
    irqEn = 1'b1;
    loadCount(32'd3);
    check(irqPending == 1'b0, "R9 not yet", {31'd0, irqPending}, 32'd0);
    fwdCycle();
    fwdCycle();
    check(count == 32'd5, "R9 count at match", count, 32'd5);
    check(irqPending == 1'b1, "R9 set on match", {31'd0, irqPending}, 32'd1);
    fwdCycle();
    check(irqPending == 1'b1, "R9 held past match", {31'd0, irqPending}, 32'd1);
    @(negedge clk);
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    check(irqPending == 1'b0, "R9 cleared", {31'd0, irqPending}, 32'd0);
    irqEn = 1'b0;
    loadCount(32'd5);
    check(irqPending == 1'b0, "R9 disabled match", {31'd0, irqPending}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule